// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block sets the bit rate of an I2C master. A down-counter is loaded with a 7-bit reload value when the transmit path strobes a buffer write. It then counts one step on each rate tick, which arrives twice per instruction cycle. Each time the count passes zero, the counter reloads itself, emits a one-cycle rollover pulse and flips the SCL level. One SCL period therefore takes two rollovers, and SCL frequency = tick rate / (2·(reload+1)).

The byte/ACK sequencer pulses a done input after the final ACK. The counter then stops where it is, and SCL keeps its last level until the next buffer write. Clearing master-mode enable sends the generator to idle with SCL high. Several instances can share one system clock and one tick, each with its own reload value, and they do not interact.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted and just after it is released, scl_o is 1, busy_o is 0 and roll_o is 0.
- R2: A start_i pulse with en_i high while idle sets busy_o on the next clock and loads the counter with reload_i.
- R3: While idle, tick_i has no effect: no roll_o pulses occur and scl_o does not change.
- R4: While busy, each tick_i decrements the count by one. A tick that finds the count at zero reloads it, pulses roll_o for one cycle and inverts scl_o. So one SCL half period lasts reload+1 ticks and one full period lasts 2·(reload+1) ticks.
- R5: A change of reload_i during a transfer only takes effect when the next rollover reloads the counter.
- R6: done_i while busy clears busy_o on the next clock. It overrides a tick in the same cycle. Afterwards the count and scl_o are frozen and no roll_o occurs.
- R7: With en_i low, busy_o goes to 0 and scl_o to 1 on the next clock, and start_i is ignored.
- R8: start_i during a transfer is ignored and does not restart the count.
- R9: Two instances on one clock and tick with different reload values each produce their own period.
- R10: Reload 0 makes scl_o invert on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master-mode enable |
| tick_i | input | 1 | Count enable at twice the instruction rate |
| reload_i | input | 7 | Reload value (0 to 127) |
| start_i | input | 1 | Transmit buffer write strobe |
| done_i | input | 1 | Transfer complete from the byte/ACK sequencer |
| scl_o | output | 1 | SCL level |
| busy_o | output | 1 | Generator is counting |
| roll_o | output | 1 | One-cycle pulse at each rollover |

## Verification
The tick runs at half the clock rate. SCL periods are measured for reload values 00h, 09h, 18h and 63h, which separate an off-by-one in the reload from a wrong tick scale. Reload 0 also checks the degenerate case where SCL flips on every tick. Further patterns cover these cases:
- a reload change in mid-transfer, to tell reload-at-rollover apart from immediate load;
- a start strobe in mid-transfer, which must be ignored;
- done pulses, which must freeze SCL at either level;
- enable drops;
- two instances counting different reloads at the same time.

A behavioural model checks every output on every clock.

// File: rtl/scl_rate_gen_pkg.sv
package scl_rate_gen_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/scl_rate_cnt.sv
module scl_rate_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] reload_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (load_i)   cnt_q <= reload_i;
    else if (wrap_o)   cnt_q <= reload_i;  // reload taken only here
    else if (step_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/scl_rate_ctrl.sv
module scl_rate_ctrl
  import scl_rate_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic start_i,
  input  logic done_i,
  input  logic wrap_i,
  output logic clear_o,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic scl_o,
  output logic roll_o
);
  run_state_e state_q;
  logic       scl_q, roll_q;

  assign busy_o  = (state_q == ST_RUN);
  assign clear_o = !en_i;
  assign load_o  = en_i && start_i && !busy_o;
  // done wins over a tick in the same cycle
  assign step_o  = en_i && busy_o && tick_i && !done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b1;
      roll_q  <= 1'b0;
    end else begin
      roll_q <= wrap_i;
      if (!en_i) begin
        state_q <= ST_IDLE;
        scl_q   <= 1'b1;
      end else begin
        if (busy_o && done_i) state_q <= ST_IDLE;
        else if (load_o)      state_q <= ST_RUN;
        if (wrap_i)           scl_q   <= !scl_q;
      end
    end
  end

  assign scl_o  = scl_q;
  assign roll_o = roll_q;
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                start_i,
  input  logic                done_i,
  output logic                scl_o,
  output logic                busy_o,
  output logic                roll_o
);
  logic clear, load, step, wrap;

  scl_rate_cnt #(.W(RELOAD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .load_i   (load),
    .step_i   (step),
    .reload_i (reload_i),
    .wrap_o   (wrap)
  );

  scl_rate_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick_i),
    .start_i (start_i),
    .done_i  (done_i),
    .wrap_i  (wrap),
    .clear_o (clear),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .scl_o   (scl_o),
    .roll_o  (roll_o)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic start_i,
  input logic done_i,
  input logic scl_o,
  input logic busy_o,
  input logic roll_o
);
  p_start_sets_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && en_i) |=> busy_o);

  p_busy_rise_needs_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_roll_only_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_o |-> $past(busy_o));

  p_scl_moves_on_roll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(scl_o) && $past(en_i)) |-> roll_o);

  p_done_freezes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i && en_i) |=> (!busy_o && $stable(scl_o) && !roll_o));

  p_disable_idles_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && scl_o));
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .start_i (start_i),
  .done_i  (done_i),
  .scl_o   (scl_o),
  .busy_o  (busy_o),
  .roll_o  (roll_o)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic en = 1;
  logic tick = 0;
  logic [6:0] rl [2];
  logic st [2];
  logic dn [2];
  logic scl [2];
  logic busy [2];
  logic roll [2];

  int checks = 0, errors = 0, cyc = 0;
  int rolls_seen [2];
  string cur_req = "R1";
  bit finished = 0;

  int  m_cnt [2];
  bit  m_scl [2], m_busy [2], m_roll [2];

  always #4 clk = ~clk;  // 125 MHz

  scl_rate_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .reload_i(rl[0]),
    .start_i(st[0]), .done_i(dn[0]), .scl_o(scl[0]), .busy_o(busy[0]), .roll_o(roll[0]));

  scl_rate_gen dut_b (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .reload_i(rl[1]),
    .start_i(st[1]), .done_i(dn[1]), .scl_o(scl[1]), .busy_o(busy[1]), .roll_o(roll[1]));

  // tick at half the clock rate
  always @(negedge clk) tick <= ~tick;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_cnt[i] = 0; m_scl[i] = 1; m_busy[i] = 0; m_roll[i] = 0;
      end else begin
        m_roll[i] = 0;
        if (!en) begin
          m_busy[i] = 0; m_scl[i] = 1; m_cnt[i] = 0;
        end else if (m_busy[i]) begin
          if (dn[i]) m_busy[i] = 0;
          else if (tick) begin
            if (m_cnt[i] == 0) begin
              m_cnt[i] = int'(rl[i]); m_scl[i] = !m_scl[i]; m_roll[i] = 1;
            end else m_cnt[i] = m_cnt[i] - 1;
          end
        end else if (st[i]) begin
          m_busy[i] = 1; m_cnt[i] = int'(rl[i]);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int i = 0; i < 2; i++) begin
        if (roll[i]) rolls_seen[i]++;
        check(scl[i] === m_scl[i] && busy[i] === m_busy[i] && roll[i] === m_roll[i],
              cur_req, {29'd0, scl[i], busy[i], roll[i]},
              {29'd0, m_scl[i], m_busy[i], m_roll[i]});
      end
    end
  end

  task automatic go(int i, logic [6:0] r);
    @(negedge clk); rl[i] = r; st[i] = 1;
    @(negedge clk); st[i] = 0;
  endtask

  task automatic stop(int i);
    @(negedge clk); dn[i] = 1;
    @(negedge clk); dn[i] = 0;
  endtask

  task automatic wait_rise(int i);
    logic prev;
    prev = scl[i];
    forever begin
      @(negedge clk);
      if (!prev && scl[i]) break;
      prev = scl[i];
    end
  endtask

  task automatic measure(int i, int exp, string req);
    int t0;
    wait_rise(i); t0 = cyc;
    wait_rise(i);
    check(cyc - t0 == exp, req, cyc - t0, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    logic held;
    for (int i = 0; i < 2; i++) begin rl[i] = 0; st[i] = 0; dn[i] = 0; rolls_seen[i] = 0; end
    repeat (4) @(negedge clk);
    check(scl[0] === 1 && busy[0] === 0 && roll[0] === 0, "R1", {29'd0, scl[0], busy[0], roll[0]}, 4);
    rst_n = 1;
    @(negedge clk);
    check(scl[0] === 1 && busy[0] === 0, "R1", {30'd0, scl[0], busy[0]}, 2);

    cur_req = "R3";
    repeat (20) @(negedge clk);
    check(rolls_seen[0] == 0 && scl[0] === 1, "R3", rolls_seen[0], 0);

    cur_req = "R2";
    go(0, 7'h09);
    check(busy[0] === 1, "R2", busy[0], 1);

    cur_req = "R4";
    measure(0, 4 * (9 + 1), "R4 reload 09h");
    stop(0);
    go(0, 7'h18);
    measure(0, 4 * (24 + 1), "R4 reload 18h");
    stop(0);
    go(0, 7'h63);
    measure(0, 4 * (99 + 1), "R4 reload 63h");
    stop(0);
    cur_req = "R10";
    go(0, 7'h00);
    measure(0, 4, "R10 reload 00h");
    stop(0);

    cur_req = "R6";
    go(0, 7'h09);
    repeat (30) @(negedge clk);
    held = scl[0];
    dn[0] = 1; @(negedge clk); dn[0] = 0;
    check(busy[0] === 0, "R6 busy", busy[0], 0);
    rolls_seen[0] = 0;
    repeat (60) @(negedge clk);
    check(rolls_seen[0] == 0, "R6 rolls", rolls_seen[0], 0);
    check(scl[0] === held, "R6 scl", scl[0], held);
    go(0, 7'h09);
    repeat (63) @(negedge clk);
    held = scl[0];
    stop(0);
    repeat (20) @(negedge clk);
    check(scl[0] === held, "R6 scl second", scl[0], held);

    cur_req = "R8";
    go(0, 7'h09);
    repeat (7) @(negedge clk);
    st[0] = 1; @(negedge clk); st[0] = 0;
    measure(0, 40, "R8");

    cur_req = "R5";
    @(negedge clk); rl[0] = 7'h18;
    wait_rise(0);
    measure(0, 100, "R5");
    stop(0);

    cur_req = "R7";
    go(0, 7'h09);
    repeat (15) @(negedge clk);
    en = 0; @(negedge clk);
    check(busy[0] === 0 && scl[0] === 1, "R7", {30'd0, busy[0], scl[0]}, 1);
    st[0] = 1; @(negedge clk); st[0] = 0;
    @(negedge clk);
    check(busy[0] === 0, "R7 start ignored", busy[0], 0);
    en = 1;

    cur_req = "R9";
    go(0, 7'h09);
    go(1, 7'h18);
    measure(0, 40, "R9 inst a");
    measure(1, 100, "R9 inst b");
    stop(0);
    stop(1);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule